// File: doc/BRIEF.md
# Raster Timer Interrupt Controller

This block raises display-synchronous interrupts for a video subsystem. A 32-bit down-counter is clocked by a pixel-rate enable. When it reaches zero it reloads from a programmable 32-bit value, which software writes as two 16-bit halves. If the timer interrupt is enabled, that moment also raises a pending timer interrupt. A vertical-blank strobe raises a second pending interrupt, and an external level-3 event raises a third. Each pending flag stays set until software clears it by writing a byte to the acknowledge register.

The same frame and line strobes drive three more pieces of state. The first is a raster line counter. The second is a 3-bit auto-animation counter that advances once every speed+1 frames. The third is a freeze window: in the 50 Hz (PAL) standard it holds the timer still for 32 raster lines after vertical blank. A single read port returns the line counter, the video standard and the animation counter. Video timing is not generated here; it arrives as one-cycle line and vertical-blank strobes.

The register side is a plain single-cycle write port with no back-pressure. Every write with `reg_wr` high takes effect at that clock edge, and the read data is always valid.

Top module: `raster_irq_ctrl`

## Requirements
- R1: After reset all three interrupt outputs are 0, the line counter and animation counter are 0, and the timer, control, reload and freeze-enable registers are 0.
- R2: `reg_rdata` is {line counter in bits 15:7, zeros in bits 6:4, `pal_mode` in bit 3, animation counter in bits 2:0}.
- R3: The line counter increments on each `line_strobe` and is cleared on `vbl_strobe`; when both arrive in the same cycle it is cleared.
- R4: Address 1 holds reload bits 31:16 and address 2 holds bits 15:0. On each `pix_tick`, a nonzero timer decrements. A zero timer reloads instead, and at that tick the timer interrupt is raised if control bit 4 is set. The interrupt therefore fires every reload+1 ticks, and never while bit 4 is clear.
- R5: With control bit 5 set, a write to address 2 also loads the timer at once, using the new 32-bit value. With bit 5 clear, such a write leaves the running count untouched.
- R6: With control bit 6 set, `vbl_strobe` loads the timer from the reload value.
- R7: If address 4 bit 0 is set and `pal_mode` is 1 at `vbl_strobe`, the timer ignores `pix_tick` until 32 `line_strobe` pulses have arrived. With `pal_mode` at 0, no freeze occurs.
- R8: `vbl_strobe` sets the vertical-blank flag `irq_vblank`, and `lvl3_event` sets `irq_lvl3`.
- R9: A write to address 3 clears `irq_lvl3` with data bit 0, `irq_timer` with bit 1 and `irq_vblank` with bit 2. Zero bits leave their flag alone, and a set event in the same cycle wins over a clear.
- R10: Control bits 15:8 give a speed S. With control bit 3 clear, the animation counter increments on every (S+1)-th `vbl_strobe`. With bit 3 set, both the animation counter and its frame count hold.
- R11: The animation counter is 3 bits wide and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_tick | input | 1 | Pixel-rate count enable for the timer |
| line_strobe | input | 1 | One-cycle pulse per raster line |
| vbl_strobe | input | 1 | One-cycle pulse at start of vertical blank |
| lvl3_event | input | 1 | Event that raises the level-3 flag |
| pal_mode | input | 1 | 1 for 50 Hz, 0 for 60 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 control, 1 reload high, 2 reload low, 3 acknowledge, 4 freeze enable) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Status word (line counter, standard, animation counter) |
| irq_lvl3 | output | 1 | Level-3 pending flag |
| irq_timer | output | 1 | Timer pending flag |
| irq_vblank | output | 1 | Vertical-blank pending flag |

## Verification
The timer count cannot be read, so its state is only visible in the cycle where the timer interrupt rises. The hardest case to observe is the PAL freeze window. The stimulus selects PAL and sets the freeze enable, loads a short reload and issues vertical blank. It then interleaves many pixel ticks with 31 line strobes and shows that no interrupt appears. After the 32nd strobe it shows that the interrupt arrives exactly reload+1 ticks later. The upper reload half is reached with one long run of 65540 ticks.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
  localparam int IRQ_N   = 3;
  localparam int IRQ_L3  = 0;
  localparam int IRQ_TMR = 1;
  localparam int IRQ_VBL = 2;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_RLD_HI = 3'd1,
    RA_RLD_LO = 3'd2,
    RA_ACK    = 3'd3,
    RA_STOP   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] speed;
    logic       load_vbl;
    logic       load_low;
    logic       irq_en;
    logic       anim_hold;
  } ctrl_t;
endpackage

// File: rtl/raster_reg_decode.sv
module raster_reg_decode
  import raster_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output ctrl_t               ctrl,
  output logic [CNT_W-1:0]    reload_eff,
  output logic                stop_en,
  output logic                low_wr,
  output logic [IRQ_N-1:0]    ack_clr
);
  localparam int HALF = CNT_W / 2;

  logic [HALF-1:0] rld_hi, rld_lo;

  assign low_wr     = reg_wr && (reg_addr == RA_RLD_LO);
  assign reload_eff = {rld_hi, low_wr ? reg_wdata[HALF-1:0] : rld_lo};
  assign ack_clr    = (reg_wr && reg_addr == RA_ACK) ? reg_wdata[IRQ_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      rld_hi  <= '0;
      rld_lo  <= '0;
      stop_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl.speed     <= reg_wdata[15:8];
          ctrl.load_vbl  <= reg_wdata[6];
          ctrl.load_low  <= reg_wdata[5];
          ctrl.irq_en    <= reg_wdata[4];
          ctrl.anim_hold <= reg_wdata[3];
        end
        RA_RLD_HI: rld_hi  <= reg_wdata[HALF-1:0];
        RA_RLD_LO: rld_lo  <= reg_wdata[HALF-1:0];
        RA_STOP:   stop_en <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assert_ack_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == RA_ACK) |-> ack_clr == '0);
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int CNT_W        = 32,
  parameter int FREEZE_LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_tick,
  input  logic             line_strobe,
  input  logic             vbl_strobe,
  input  logic             pal_mode,
  input  logic             stop_en,
  input  logic [CNT_W-1:0] reload,
  input  logic             low_wr,
  input  logic             load_low,
  input  logic             load_vbl,
  input  logic             irq_en,
  output logic             expire
);
  localparam int FRZ_W = $clog2(FREEZE_LINES + 1);

  logic [CNT_W-1:0] cnt;
  logic [FRZ_W-1:0] frz_cnt;
  logic             load_now, frozen, run;

  assign load_now = (low_wr && load_low) || (vbl_strobe && load_vbl);
  assign frozen   = (frz_cnt != '0);
  assign run      = pix_tick && !frozen && !load_now;
  assign expire   = run && (cnt == '0) && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load_now) begin
      cnt <= reload;
    end else if (run) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_cnt <= '0;
    end else if (vbl_strobe && pal_mode && stop_en) begin
      frz_cnt <= FRZ_W'(FREEZE_LINES);
    end else if (line_strobe && frozen) begin
      frz_cnt <= frz_cnt - 1'b1;
    end
  end

  assert_frozen_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !expire);
  assert_frozen_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !load_now) |=> $stable(cnt));
  assert_reload_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |=> cnt == $past(reload));
  assert_load_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> cnt == $past(reload));
endmodule

// File: rtl/raster_frame_count.sv
module raster_frame_count #(
  parameter int LINE_W  = 9,
  parameter int ANIM_W  = 3,
  parameter int SPEED_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_strobe,
  input  logic               vbl_strobe,
  input  logic               anim_hold,
  input  logic [SPEED_W-1:0] speed,
  output logic [LINE_W-1:0]  line_cnt,
  output logic [ANIM_W-1:0]  anim
);
  logic [SPEED_W-1:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (vbl_strobe) begin
      line_cnt <= '0;
    end else if (line_strobe) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      anim      <= '0;
    end else if (vbl_strobe && !anim_hold) begin
      if (frame_cnt >= speed) begin
        frame_cnt <= '0;
        anim      <= anim + 1'b1;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_strobe |=> line_cnt == '0);
  assert_anim_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (anim_hold || !vbl_strobe) |=> $stable(anim));
endmodule

// File: rtl/raster_pending.sv
module raster_pending #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !pend[i]);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);
  end
endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import raster_irq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 32,
  parameter int LINE_W       = 9,
  parameter int ANIM_W       = 3,
  parameter int FREEZE_LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_tick,
  input  logic              line_strobe,
  input  logic              vbl_strobe,
  input  logic              lvl3_event,
  input  logic              pal_mode,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_lvl3,
  output logic              irq_timer,
  output logic              irq_vblank
);
  localparam int PAD_W = DATA_W - LINE_W - 1 - ANIM_W;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  reload_eff;
  logic              stop_en, low_wr, expire;
  logic [IRQ_N-1:0]  ack_clr, irq_set, pend;
  logic [LINE_W-1:0] line_cnt;
  logic [ANIM_W-1:0] anim;

  raster_reg_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl(ctrl), .reload_eff(reload_eff),
    .stop_en(stop_en), .low_wr(low_wr), .ack_clr(ack_clr)
  );

  raster_timer #(.CNT_W(CNT_W), .FREEZE_LINES(FREEZE_LINES)) u_timer (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .line_strobe(line_strobe),
    .vbl_strobe(vbl_strobe), .pal_mode(pal_mode), .stop_en(stop_en),
    .reload(reload_eff), .low_wr(low_wr), .load_low(ctrl.load_low),
    .load_vbl(ctrl.load_vbl), .irq_en(ctrl.irq_en), .expire(expire)
  );

  raster_frame_count #(.LINE_W(LINE_W), .ANIM_W(ANIM_W), .SPEED_W(8)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .vbl_strobe(vbl_strobe),
    .anim_hold(ctrl.anim_hold), .speed(ctrl.speed), .line_cnt(line_cnt), .anim(anim)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_L3]  = lvl3_event;
    irq_set[IRQ_TMR] = expire;
    irq_set[IRQ_VBL] = vbl_strobe;
  end

  raster_pending #(.N(IRQ_N)) u_pending (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(ack_clr), .pend(pend)
  );

  assign irq_lvl3   = pend[IRQ_L3];
  assign irq_timer  = pend[IRQ_TMR];
  assign irq_vblank = pend[IRQ_VBL];
  assign reg_rdata  = {line_cnt, {PAD_W{1'b0}}, pal_mode, anim};

  assert_vblank_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_strobe |=> irq_vblank);
  assert_timer_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_timer && !ctrl.irq_en) |=> !irq_timer);
endmodule

// File: tb/raster_irq_ctrl_bench.sv
`timescale 1ns/1ps
module raster_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_tick = 1'b0, line_strobe = 1'b0, vbl_strobe = 1'b0;
  logic        lvl3_event = 1'b0, pal_mode = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_lvl3, irq_timer, irq_vblank;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  raster_irq_ctrl u_raster_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .line_strobe(line_strobe),
    .vbl_strobe(vbl_strobe), .lvl3_event(lvl3_event), .pal_mode(pal_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lvl3(irq_lvl3), .irq_timer(irq_timer),
    .irq_vblank(irq_vblank)
  );

  localparam int unsigned RLD [5] = '{0, 1, 5, 17, 40};
  localparam int unsigned PER [5] = '{1, 2, 6, 18, 41};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      pix_tick = 1'b1;
      @(negedge clk);
    end
    pix_tick = 1'b0;
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) begin
      line_strobe = 1'b1;
      @(negedge clk);
    end
    line_strobe = 1'b0;
  endtask

  task automatic vbls(int n);
    for (int i = 0; i < n; i++) begin
      vbl_strobe = 1'b1;
      @(negedge clk);
      vbl_strobe = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqs", {irq_lvl3, irq_timer, irq_vblank}, 0);
    chk("R1 rdata", reg_rdata, 16'h0000);
    // R2 standard bit
    pal_mode = 1'b1; #1;
    chk("R2 pal bit", reg_rdata, 16'h0008);
    pal_mode = 1'b0;

    wr(3'd0, 16'h0008);            // hold animation
    // R3 line counter
    lines(5);
    chk("R3 line count", reg_rdata[15:7], 5);
    line_strobe = 1'b1; vbl_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0; vbl_strobe = 1'b0;
    chk("R3 clear wins", reg_rdata, 16'h0000);
    // R8 flags
    chk("R8 vblank flag", irq_vblank, 1);
    lvl3_event = 1'b1; @(negedge clk); lvl3_event = 1'b0;
    chk("R8 lvl3 flag", irq_lvl3, 1);
    // R9 acknowledge
    wr(3'd3, 16'h00F8);
    chk("R9 zero bits keep", {irq_lvl3, irq_vblank}, 2'b11);
    wr(3'd3, 16'h0001);
    chk("R9 bit0 clears lvl3", {irq_lvl3, irq_vblank}, 2'b01);
    vbl_strobe = 1'b1; wr(3'd3, 16'h0004); vbl_strobe = 1'b0;
    chk("R9 set wins", irq_vblank, 1);
    wr(3'd3, 16'h0004);
    chk("R9 bit2 clears vblank", irq_vblank, 0);

    // R4 periods from vector table (bit3 hold, bit4 enable, bit5 load on low write)
    wr(3'd0, 16'h0038);
    wr(3'd1, 16'h0000);
    for (int k = 0; k < 5; k++) begin
      wr(3'd2, 16'(RLD[k]));
      wr(3'd3, 16'h0002);
      if (PER[k] > 1) ticks(PER[k] - 1);
      chk("R4 no early irq", irq_timer, 0);
      ticks(1);
      chk("R4 irq at period", irq_timer, 1);
    end
    // R4 upper half
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0002);
    ticks(65539);
    chk("R4 high half no early", irq_timer, 0);
    ticks(1);
    chk("R4 high half irq", irq_timer, 1);
    wr(3'd1, 16'h0000);
    // R4 enable off
    wr(3'd0, 16'h0028);
    wr(3'd2, 16'h0002);
    wr(3'd3, 16'h0002);
    ticks(7);
    chk("R4 disabled", irq_timer, 0);

    // R5 low write without load mode keeps running count
    wr(3'd0, 16'h0038);
    wr(3'd2, 16'd10);
    ticks(3);
    wr(3'd0, 16'h0018);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'h0002);
    ticks(7);
    chk("R5 no reload on write", irq_timer, 0);
    ticks(1);
    chk("R5 old count expires", irq_timer, 1);
    wr(3'd3, 16'h0002);
    ticks(2);
    chk("R5 new reload early", irq_timer, 0);
    ticks(1);
    chk("R5 new reload period", irq_timer, 1);

    // R6 load at vertical blank
    wr(3'd0, 16'h0038);
    wr(3'd2, 16'd20);
    wr(3'd0, 16'h0058);
    wr(3'd2, 16'd4);
    ticks(5);
    vbls(1);
    wr(3'd3, 16'h0007);
    ticks(4);
    chk("R6 early", irq_timer, 0);
    ticks(1);
    chk("R6 vblank load", irq_timer, 1);

    // R7 PAL freeze window
    pal_mode = 1'b1;
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0038);
    wr(3'd2, 16'd3);
    vbls(1);
    wr(3'd3, 16'h0007);
    ticks(10);
    chk("R7 frozen", irq_timer, 0);
    for (int l = 0; l < 31; l++) begin
      lines(1);
      ticks(2);
    end
    chk("R7 frozen after 31 lines", irq_timer, 0);
    lines(1);
    ticks(3);
    chk("R7 released early", irq_timer, 0);
    ticks(1);
    chk("R7 released period", irq_timer, 1);
    pal_mode = 1'b0;
    wr(3'd2, 16'd3);
    vbls(1);
    wr(3'd3, 16'h0007);
    ticks(3);
    chk("R7 ntsc early", irq_timer, 0);
    ticks(1);
    chk("R7 ntsc no freeze", irq_timer, 1);
    wr(3'd4, 16'h0000);

    // R10 animation pacing, speed 2
    wr(3'd0, 16'h0200);
    vbls(2);
    chk("R10 before pace", reg_rdata[2:0], 0);
    vbls(1);
    chk("R10 third frame", reg_rdata[2:0], 1);
    wr(3'd0, 16'h0208);
    vbls(5);
    chk("R10 hold", reg_rdata[2:0], 1);
    // R11 wrap at speed 0
    wr(3'd0, 16'h0000);
    vbls(6);
    chk("R11 reach 7", reg_rdata[2:0], 7);
    vbls(1);
    chk("R11 wrap", reg_rdata[2:0], 0);

    summary();
  end
endmodule